// File: doc/BRIEF.md
# Bit-Serial Associative Minimum Finder

This block holds one result word per processing element and finds the smallest of them, together with the index of an element that holds it. It does not compare elements against each other. It builds a search key one bit at a time, starting at the most significant bit. At each step every element checks its word against the key bits resolved so far and raises a match flag. One OR across all flags then decides whether the bit under trial is 0 or 1.

A pulse on `start` loads the element words from `elem_vals` and runs the search. When the key is complete, a lowest-index-first resolver keeps a single flagged element and an encoder turns it into a binary index. The key is the minimum. The minimum and the index are registered and announced with a one-cycle `done` pulse. The number of steps depends only on the word width, never on the element count.

Top module: `cam_min_search`

## Requirements
- R1: While `rst` is high and after it falls, `done`, `min_val` and `win_idx` are all zero until the first search completes.
- R2: When `done` is high, `min_val` equals the smallest of the N words captured from `elem_vals`, where element e occupies bits [e*W+W-1 : e*W].
- R3: When `done` is high, `win_idx` is the index of an element whose captured word equals `min_val`; if several elements hold the minimum, it is the lowest such index.
- R4: `done` rises exactly 4*W+5 clock edges (53 for W=12) after the edge that samples `start` high in idle, whatever the value of N and the data.
- R5: `done` is high for exactly one clock cycle per search.
- R6: The element words are captured at the edge that samples `start`; changes on `elem_vals` during the search have no effect on `min_val` or `win_idx`.
- R7: `start` is ignored while a search is in progress; it neither restarts the search nor moves the time of `done`.
- R8: `min_val` and `win_idx` keep their values between searches, until the next search writes them.
- R9: Extreme data is handled: all words equal gives index 0, a minimum of 0 and a minimum of 2^W-1 are both reported exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when sampled high in idle |
| elem_vals | input | N*W | Packed element words, element 0 in the low bits |
| min_val | output | W | Minimum found by the last search |
| win_idx | output | max(1,clog2(N)) | Index of the element holding the minimum |
| done | output | 1 | One-cycle pulse when the outputs are new |

## Verification
The bench uses the defaults N=8 and W=12. With 12-bit words it can place a minimum of 0 or of 4095 and values that split at the top bit (0x7FF against 0x800), so every key bit is resolved both ways. Eight elements leave room for ties at interior and edge positions, which tests lowest-index resolution away from element 0. With W=12 the expected latency is the 53-edge figure, and it is checked on every search.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_ARM,
        S_CMP,
        S_OR,
        S_FIX,
        S_FINAL,
        S_PICK,
        S_ENC,
        S_REPORT
    } cms_state_e;

    // Broadcast strobes from the sequencer to the array
    typedef struct packed {
        logic capture;   // latch element words
        logic cmp;       // every element re-compares against key
        logic pick;      // resolver registers one grant
        logic enc;       // outputs take key and encoded index
        logic report;    // done pulse
    } cms_ctl_t;

    function automatic int unsigned cms_latency(input int unsigned w);
        return 4 * w + 5;
    endfunction

    function automatic int unsigned cms_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cms_element.sv
module cms_element
    import cms_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  cms_ctl_t     ctl,
    input  logic [W-1:0] val_in,
    input  logic [W-1:0] key,
    input  logic [W-1:0] care,
    output logic         flag
);

    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            flag   <= 1'b0;
        end else if (ctl.capture) begin
            word_q <= val_in;
            flag   <= 1'b0;
        end else if (ctl.cmp) begin
            flag   <= (((word_q ^ key) & care) == '0);
        end
    end

endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
    import cms_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         any_hit,
    output cms_ctl_t     ctl,
    output logic [W-1:0] key,
    output logic [W-1:0] care
);

    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);

    cms_state_e    state;
    logic [BW-1:0] bit_q;
    logic          any_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            key   <= '0;
            care  <= '0;
            bit_q <= '0;
            any_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE:   if (start) state <= S_LOAD;
                S_LOAD: begin
                    key   <= '0;
                    care  <= '0;
                    bit_q <= TOP_BIT;
                    state <= S_ARM;
                end
                S_ARM: begin
                    key[bit_q]  <= 1'b0;
                    care[bit_q] <= 1'b1;
                    state       <= S_CMP;
                end
                S_CMP:    state <= S_OR;
                S_OR: begin
                    any_q <= any_hit;
                    state <= S_FIX;
                end
                S_FIX: begin
                    if (!any_q) key[bit_q] <= 1'b1;
                    if (bit_q == '0) begin
                        state <= S_FINAL;
                    end else begin
                        bit_q <= bit_q - 1'b1;
                        state <= S_ARM;
                    end
                end
                S_FINAL:  state <= S_PICK;
                S_PICK:   state <= S_ENC;
                S_ENC:    state <= S_REPORT;
                S_REPORT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.capture = (state == S_IDLE) && start;
        ctl.cmp     = (state == S_CMP) || (state == S_FINAL);
        ctl.pick    = (state == S_PICK);
        ctl.enc     = (state == S_ENC);
        ctl.report  = (state == S_REPORT);
    end

    // R7
    busy_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |-> !ctl.capture);

endmodule

// File: rtl/cms_resolver.sv
module cms_resolver
    import cms_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  cms_ctl_t      ctl,
    input  logic [N-1:0]  flags,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);

    logic [N-1:0] lowest;

    // isolate lowest set flag: lowest index wins a tie
    assign lowest = flags & (~flags + N'(1));

    always_ff @(posedge clk) begin
        if (rst || ctl.capture) grant <= '0;
        else if (ctl.pick)      grant <= lowest;
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    // R3
    grant_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    grant_flagged_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~flags) == '0);

endmodule

// File: rtl/cam_min_search.sv
module cam_min_search
    import cms_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 12,
    localparam int IW = cms_idx_w(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N*W-1:0] elem_vals,
    output logic [W-1:0]   min_val,
    output logic [IW-1:0]  win_idx,
    output logic           done
);

    cms_ctl_t      ctl;
    logic [W-1:0]  key;
    logic [W-1:0]  care;
    logic [N-1:0]  flags;
    logic [N-1:0]  grant;
    logic [IW-1:0] idx;
    logic          any_hit;

    cms_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .any_hit (any_hit),
        .ctl     (ctl),
        .key     (key),
        .care    (care)
    );

    for (genvar g = 0; g < N; g++) begin : g_elem
        cms_element #(.W(W)) u_elem (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .val_in (elem_vals[g*W +: W]),
            .key    (key),
            .care   (care),
            .flag   (flags[g])
        );
    end

    // global any-match line
    assign any_hit = |flags;

    cms_resolver #(.N(N), .IW(IW)) u_res (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .flags (flags),
        .grant (grant),
        .idx   (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            min_val <= '0;
            win_idx <= '0;
            done    <= 1'b0;
        end else begin
            if (ctl.enc) begin
                min_val <= key;
                win_idx <= idx;
            end
            done <= ctl.report;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_has_winner_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(grant) == 1));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.enc |=> ($stable(min_val) && $stable(win_idx)));

endmodule

// File: tb/test_cam_min_search.sv
module test_cam_min_search;

    localparam int N   = 8;
    localparam int W   = 12;
    localparam int IW  = 3;
    localparam int LAT = 4 * W + 5;
    localparam int NV  = 6;

    // rows written {e7,e6,e5,e4,e3,e2,e1,e0}
    localparam logic [N*W-1:0] VEC [NV] = '{
        {12'd900, 12'd55,   12'd700,  12'd300,  12'd55,   12'd1000, 12'd2000, 12'd123},
        {12'hFFF, 12'hFFF,  12'hFFF,  12'hFFF,  12'hFFF,  12'hFFF,  12'hFFF,  12'hFFF},
        {12'd0,   12'd4095, 12'd2048, 12'd2047, 12'd1,    12'd3000, 12'd17,   12'd800},
        {12'h800, 12'h7FF,  12'hFFF,  12'h400,  12'h3FF,  12'h801,  12'h7FE,  12'hC00},
        {12'h000, 12'h000,  12'h000,  12'h000,  12'h000,  12'h000,  12'h000,  12'h000},
        {12'd5,   12'd5,    12'd6,    12'd7,    12'd8,    12'd9,    12'd10,   12'd6}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N*W-1:0] elem_vals = '0;
    logic [W-1:0]   min_val;
    logic [IW-1:0]  win_idx;
    logic           done;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cam_min_search #(.N(N), .W(W)) i_cam_min_search (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .elem_vals (elem_vals),
        .min_val   (min_val),
        .win_idx   (win_idx),
        .done      (done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_min(input logic [N*W-1:0] v);
        int m = int'(v[W-1:0]);
        for (int e = 1; e < N; e++)
            if (int'(v[e*W +: W]) < m) m = int'(v[e*W +: W]);
        return m;
    endfunction

    function automatic int exp_idx(input logic [N*W-1:0] v);
        int m = int'(v[W-1:0]);
        int k = 0;
        for (int e = 1; e < N; e++)
            if (int'(v[e*W +: W]) < m) begin
                m = int'(v[e*W +: W]);
                k = e;
            end
        return k;
    endfunction

    // start sampled at edge 0; returns the edge count where done is first seen
    task automatic launch(input logic [N*W-1:0] v);
        @(negedge clk);
        elem_vals = v;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = -1;
        for (int k = 1; k <= LAT + 20; k++) begin
            @(posedge clk);
            #1;
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [W-1:0]  held_min;
        logic [IW-1:0] held_idx;

        repeat (3) @(posedge clk);
        #1;
        // R1: during reset
        check("R1 done in reset", int'(done), 0);
        check("R1 min_val in reset", int'(min_val), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R1: after reset, before any search
        check("R1 done idle", int'(done), 0);
        check("R1 min_val idle", int'(min_val), 0);
        check("R1 win_idx idle", int'(win_idx), 0);

        // table walk: R2, R3, R4, R5, R9
        for (int r = 0; r < NV; r++) begin
            launch(VEC[r]);
            wait_done(lat);
            check("R4 latency", lat, LAT);
            check("R2 minimum", int'(min_val), exp_min(VEC[r]));
            check("R3 index", int'(win_idx), exp_idx(VEC[r]));
            @(posedge clk);
            #1;
            check("R5 done one cycle", int'(done), 0);
        end
        // R9 explicit extremes
        check("R9 all equal index", exp_idx(VEC[1]), 0);

        // R6: inputs change after capture
        launch(VEC[0]);
        repeat (2) @(posedge clk);
        #1 elem_vals = '0;
        wait_done(lat);
        check("R6 latency", lat, LAT - 2);
        check("R6 minimum unaffected", int'(min_val), 55);
        check("R6 index unaffected", int'(win_idx), 3);

        // R7: start during busy ignored
        launch(VEC[3]);
        repeat (9) @(posedge clk);
        @(negedge clk);
        elem_vals = VEC[4];
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        wait_done(lat);
        check("R7 done not delayed", lat, LAT - 10);
        check("R7 minimum from first data", int'(min_val), 12'h3FF);
        check("R7 index from first data", int'(win_idx), 3);
        wait_done(lat);
        check("R7 no second search", lat, -1);

        // R8: outputs hold between searches
        held_min = min_val;
        held_idx = win_idx;
        elem_vals = VEC[2];
        repeat (15) @(posedge clk);
        #1;
        check("R8 min_val held", int'(min_val), int'(held_min));
        check("R8 win_idx held", int'(win_idx), int'(held_idx));

        // R1: reset mid-search clears outputs
        launch(VEC[5]);
        repeat (20) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 min_val after reset", int'(min_val), 0);
        check("R1 done after reset", int'(done), 0);
        @(negedge clk) rst = 1'b0;
        wait_done(lat);
        check("R1 no done after aborted search", lat, -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule